// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer with Mode Freeze

This block is a periodic interrupt source. A counter counts down by one on each enabled clock. When it is at zero and takes one more step, it reloads from a modulus register and raises a sticky interrupt flag. The interrupt output follows that flag whenever interrupts are enabled. Software reaches the block through a small single-cycle register port. Each access carries a privilege qualifier, and the port answers at once with read data and a transfer-error indication.

Two chip-level mode inputs, one for doze and one for debug, can each stop the counter. Each one stops it only if its own freeze bit in the control register is set. When the mode ends, counting picks up from the value that was held. Register writes still take effect while the counter is frozen. Stop mode is modelled by holding the clock-enable input low, which halts the counter. Wait mode needs no input of its own, because the timer runs normally there and its interrupt can wake the system.

Top module: `pit_timer`

## Requirements
- R1: After reset, a supervisor read returns 0x0000 at offset 0x0 (control), 0xFFFF at offset 0x2 (modulus) and 0xFFFF at offset 0x4 (count), and irq is low.
- R2: With the enable bit (control bit 0) set, the count falls by one on each clock where clkEn is high and no freeze applies. With the enable bit clear, the count holds.
- R3: A step taken while the count is 0x0000 loads the count from the modulus register and sets the flag (control bit 2). A period is therefore modulus plus one steps.
- R4: irq is high exactly when the flag is set and the interrupt-enable bit (control bit 3) is set.
- R5: Writing 1 to control bit 2 clears the flag, and writing 0 there leaves it unchanged. If an underflow happens in the same cycle as the clear, the flag stays set.
- R6: When the load-on-write bit (control bit 1) is set, a modulus write also loads the count in the same cycle. When that bit is clear, only the modulus changes.
- R7: While dozeMode is high and the doze-freeze bit (control bit 5) is set, the count holds. Counting resumes from the held value when dozeMode falls. If the bit is clear, doze has no effect.
- R8: While dbgMode is high and the debug-freeze bit (control bit 4) is set, the count holds. If the bit is clear, debug has no effect. Register writes made during debug stay in effect.
- R9: While clkEn is low the count does not advance, and it resumes from the same value when clkEn returns high.
- R10: A user-state access (busSuper low) to offset 0x0 or 0x2 is ignored and sets busErr. The count at 0x4 can be read in either state without error.
- R11: An access to any other offset (0x1, 0x3, 0x5, 0x6, 0x7), or any write to 0x4, changes nothing, sets busErr and returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkEn | input | 1 | Counter clock enable; low models stop mode |
| dozeMode | input | 1 | System is in doze mode |
| dbgMode | input | 1 | System is in debug mode |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busSuper | input | 1 | Access is made in supervisor state |
| busAddr | input | 3 | Byte offset of the register |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data, 0 when no valid read is made |
| busErr | output | 1 | Transfer error for the current access |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default CNT_W of 16, so the reset value of all ones and the full register layout are checked as shipped. It programs small modulus values of two to nine, which puts several complete reload cycles within a few dozen clocks. A freeze entry and exit, a modulus write during debug, and a stop interval can each be placed on a known counter value and read back cycle by cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MOD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 3'd4;

  // control register bit positions
  localparam int B_EN      = 0;
  localparam int B_WRLOAD  = 1;
  localparam int B_FLAG    = 2;
  localparam int B_IRQEN   = 3;
  localparam int B_DBGFRZ  = 4;
  localparam int B_DOZEFRZ = 5;
  localparam int CTRL_BITS = 6;

  typedef struct packed {
    logic step;     // advance the counter this cycle
    logic modWr;    // modulus register write
    logic loadNow;  // copy write data into the counter
  } pitStrobe_t;
endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pitStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] modVal,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ZERO     = '0;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] modQ;

  assign underflow = strb.step && !strb.loadNow && (cntQ == ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= ALL_ONES;
    end else if (strb.modWr) begin
      modQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= ALL_ONES;
    end else if (strb.loadNow) begin
      cntQ <= wrData;
    end else if (strb.step) begin
      if (cntQ == ZERO) cntQ <= modQ;
      else              cntQ <= cntQ - ONE;
    end
  end

  assign cntVal = cntQ;
  assign modVal = modQ;
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 dozeMode,
  input  logic                 dbgMode,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic                 busSuper,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CTRL_BITS-1:0] ctrlWdata,
  input  logic [CNT_W-1:0]     cntVal,
  input  logic [CNT_W-1:0]     modVal,
  input  logic                 underflow,
  output pitStrobe_t           strb,
  output logic [CNT_W-1:0]     ctrlVal,
  output logic [CNT_W-1:0]     busRdata,
  output logic                 busErr,
  output logic                 irq
);
  logic enQ, wrLoadQ, flagQ, irqEnQ, dbgFrzQ, dozeFrzQ;
  logic hitCtrl, hitMod, hitCnt;
  logic badOff, privFail, accOk;
  logic ctrlWr, frozen;

  // address decode and access checks
  assign hitCtrl  = (busAddr == OFF_CTRL);
  assign hitMod   = (busAddr == OFF_MOD);
  assign hitCnt   = (busAddr == OFF_CNT);
  assign badOff   = !(hitCtrl || hitMod || hitCnt) || (hitCnt && busWr);
  assign privFail = !busSuper && (hitCtrl || hitMod);
  assign accOk    = busSel && !badOff && !privFail;
  assign busErr   = busSel && (badOff || privFail);

  assign ctrlWr = accOk && busWr && hitCtrl;

  // freeze decision: each mode stops counting only under its own bit
  assign frozen = (dozeMode && dozeFrzQ) || (dbgMode && dbgFrzQ);

  always_comb begin
    strb.step    = enQ && clkEn && !frozen;
    strb.modWr   = accOk && busWr && hitMod;
    strb.loadNow = accOk && busWr && hitMod && wrLoadQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      wrLoadQ  <= 1'b0;
      irqEnQ   <= 1'b0;
      dbgFrzQ  <= 1'b0;
      dozeFrzQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ      <= ctrlWdata[B_EN];
      wrLoadQ  <= ctrlWdata[B_WRLOAD];
      irqEnQ   <= ctrlWdata[B_IRQEN];
      dbgFrzQ  <= ctrlWdata[B_DBGFRZ];
      dozeFrzQ <= ctrlWdata[B_DOZEFRZ];
    end
  end

  // sticky flag: set on underflow wins over a write-1 clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (underflow) begin
      flagQ <= 1'b1;
    end else if (ctrlWr && ctrlWdata[B_FLAG]) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlVal            = '0;
    ctrlVal[B_EN]      = enQ;
    ctrlVal[B_WRLOAD]  = wrLoadQ;
    ctrlVal[B_FLAG]    = flagQ;
    ctrlVal[B_IRQEN]   = irqEnQ;
    ctrlVal[B_DBGFRZ]  = dbgFrzQ;
    ctrlVal[B_DOZEFRZ] = dozeFrzQ;
  end

  always_comb begin
    busRdata = '0;
    if (accOk && !busWr) begin
      if (hitCtrl)     busRdata = ctrlVal;
      else if (hitMod) busRdata = modVal;
      else             busRdata = cntVal;
    end
  end

  assign irq = flagQ && irqEnQ;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              dozeMode,
  input  logic              dbgMode,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busSuper,
  input  logic [2:0]        busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              busErr,
  output logic              irq
);
  pitStrobe_t       strb;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] modVal;
  logic [CNT_W-1:0] ctrlVal;
  logic             underflow;

  pit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .dozeMode  (dozeMode),
    .dbgMode   (dbgMode),
    .busSel    (busSel),
    .busWr     (busWr),
    .busSuper  (busSuper),
    .busAddr   (busAddr),
    .ctrlWdata (busWdata[CTRL_BITS-1:0]),
    .cntVal    (cntVal),
    .modVal    (modVal),
    .underflow (underflow),
    .strb      (strb),
    .ctrlVal   (ctrlVal),
    .busRdata  (busRdata),
    .busErr    (busErr),
    .irq       (irq)
  );

  pit_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWdata),
    .cntVal    (cntVal),
    .modVal    (modVal),
    .underflow (underflow)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             dozeMode,
  input logic             dbgMode,
  input logic             busSel,
  input logic             busSuper,
  input logic [2:0]       busAddr,
  input logic [CNT_W-1:0] busRdata,
  input logic             busErr,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] modVal,
  input logic [CNT_W-1:0] ctrlVal,
  input logic             step,
  input logic             loadNow
);
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && !loadNow && cntVal == '0) |=> (cntVal == $past(modVal) && ctrlVal[2]));

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlVal[2] && ctrlVal[3]));

  // R7
  doze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dozeMode && ctrlVal[5] && !loadNow) |=> (cntVal == $past(cntVal)));

  // R8
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgMode && ctrlVal[4] && !loadNow) |=> (cntVal == $past(cntVal)));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && !loadNow) |=> (cntVal == $past(cntVal)));

  // R10
  user_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busSuper && (busAddr == 3'd0 || busAddr == 3'd2)) |-> busErr);

  // R11
  odd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr[0]) |-> (busErr && busRdata == '0));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .dozeMode (dozeMode),
  .dbgMode  (dbgMode),
  .busSel   (busSel),
  .busSuper (busSuper),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .busErr   (busErr),
  .irq      (irq),
  .cntVal   (cntVal),
  .modVal   (modVal),
  .ctrlVal  (ctrlVal),
  .step     (strb.step),
  .loadNow  (strb.loadNow)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic dozeMode = 1'b0;
  logic dbgMode = 1'b0;
  logic busSel = 1'b0;
  logic busWr = 1'b0;
  logic busSuper = 1'b1;
  logic [2:0] busAddr = '0;
  logic [CNT_W-1:0] busWdata = '0;
  logic [CNT_W-1:0] busRdata;
  logic busErr;
  logic irq;

  always #2 clk = ~clk;  // 250 MHz

  pit_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dozeMode(dozeMode), .dbgMode(dbgMode),
    .busSel(busSel), .busWr(busWr), .busSuper(busSuper), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .irq(irq)
  );

  // kind 0: read data + error, 1: error only, 2: irq level
  typedef struct {
    int          kind;
    logic [15:0] exp;
    logic        err;
    string       req;
  } item_t;

  item_t expQ[$];
  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      nChk++;
      case (it.kind)
        0: if (busRdata !== it.exp || busErr !== it.err) begin
             nFail++;
             $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                      it.req, busRdata, busErr, it.exp, it.err);
           end
        1: if (busErr !== it.err) begin
             nFail++;
             $display("FAIL %s: err=%b expected %b", it.req, busErr, it.err);
           end
        default: if (irq !== it.exp[0]) begin
             nFail++;
             $display("FAIL %s: irq=%b expected %b", it.req, irq, it.exp[0]);
           end
      endcase
    end
  end

  task automatic rd(input logic [2:0] a, input logic sup, input logic [15:0] exp,
                    input logic expErr, input string req);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busSuper = sup;
    #1;
    expQ.push_back('{0, exp, expErr, req});
    @(negedge clk);
    busSel = 1'b0; busSuper = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic sup, input logic [15:0] d,
                    input logic expErr, input string req);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busSuper = sup; busWdata = d;
    #1;
    expQ.push_back('{1, 16'h0, expErr, req});
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busSuper = 1'b1;
  endtask

  task automatic rdCnt(input logic [15:0] exp, input string req);
    rd(3'd4, 1'b1, exp, 1'b0, req);
  endtask

  task automatic chkIrq(input logic expIrq, input string req);
    expQ.push_back('{2, {15'h0, expIrq}, 1'b0, req});
    #0;
  endtask

  // stop, clear flag, load counter with n, then apply configuration
  task automatic arm(input logic [15:0] n, input logic [15:0] cfg);
    wr(3'd0, 1'b1, 16'h0002, 1'b0, "R6");
    wr(3'd0, 1'b1, 16'h0006, 1'b0, "R5");
    wr(3'd2, 1'b1, n, 1'b0, "R6");
    wr(3'd0, 1'b1, cfg, 1'b0, "R2");
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run hung, expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, 1'b1, 16'h0000, 1'b0, "R1");
    rd(3'd2, 1'b1, 16'hFFFF, 1'b0, "R1");
    rd(3'd4, 1'b1, 16'hFFFF, 1'b0, "R1");
    chkIrq(1'b0, "R1");

    // R10 privilege
    rd(3'd4, 1'b0, 16'hFFFF, 1'b0, "R10");
    rd(3'd0, 1'b0, 16'h0000, 1'b1, "R10");
    wr(3'd2, 1'b0, 16'h1234, 1'b1, "R10");
    wr(3'd0, 1'b0, 16'h0001, 1'b1, "R10");
    rd(3'd2, 1'b1, 16'hFFFF, 1'b0, "R10");
    rd(3'd0, 1'b1, 16'h0000, 1'b0, "R10");

    // R11 reserved offsets and count write
    rd(3'd6, 1'b1, 16'h0000, 1'b1, "R11");
    rd(3'd3, 1'b1, 16'h0000, 1'b1, "R11");
    wr(3'd1, 1'b1, 16'h0001, 1'b1, "R11");
    wr(3'd4, 1'b1, 16'h0010, 1'b1, "R11");
    wr(3'd7, 1'b1, 16'hAAAA, 1'b1, "R11");
    rd(3'd4, 1'b1, 16'hFFFF, 1'b0, "R11");
    rd(3'd0, 1'b1, 16'h0000, 1'b0, "R11");

    // R6 load on modulus write, on and off; R2 hold while disabled
    wr(3'd0, 1'b1, 16'h0002, 1'b0, "R6");
    wr(3'd2, 1'b1, 16'h0003, 1'b0, "R6");
    rdCnt(16'h0003, "R6");
    wr(3'd0, 1'b1, 16'h0000, 1'b0, "R6");
    wr(3'd2, 1'b1, 16'h0007, 1'b0, "R6");
    rdCnt(16'h0003, "R6");
    rdCnt(16'h0003, "R2");
    rd(3'd2, 1'b1, 16'h0007, 1'b0, "R6");
    wr(3'd0, 1'b1, 16'h0001, 1'b0, "R2");
    rdCnt(16'h0003, "R2");
    rdCnt(16'h0002, "R2");
    rdCnt(16'h0001, "R2");
    rdCnt(16'h0000, "R2");
    rdCnt(16'h0007, "R3");
    chkIrq(1'b0, "R4");
    rd(3'd0, 1'b1, 16'h0005, 1'b0, "R3");
    wr(3'd0, 1'b1, 16'h0004, 1'b0, "R5");
    rd(3'd0, 1'b1, 16'h0000, 1'b0, "R5");

    // R3/R4/R5 periodic interrupt with irq enabled
    arm(16'h0005, 16'h000B);
    for (int v = 5; v >= 0; v--) rdCnt(16'(v), "R3");
    rdCnt(16'h0005, "R3");
    chkIrq(1'b1, "R4");
    rd(3'd0, 1'b1, 16'h000F, 1'b0, "R3");
    wr(3'd0, 1'b1, 16'h000F, 1'b0, "R5");
    chkIrq(1'b0, "R5");
    rd(3'd0, 1'b1, 16'h000B, 1'b0, "R5");

    // R7 doze with freeze bit set
    arm(16'h0003, 16'h002B);
    dozeMode = 1'b1;
    rdCnt(16'h0003, "R7"); rdCnt(16'h0003, "R7"); rdCnt(16'h0003, "R7");
    dozeMode = 1'b0;
    rdCnt(16'h0003, "R7"); rdCnt(16'h0002, "R7"); rdCnt(16'h0001, "R7");
    rdCnt(16'h0000, "R7"); rdCnt(16'h0003, "R7");
    chkIrq(1'b1, "R7");

    // R7 doze with freeze bit clear
    arm(16'h0003, 16'h000B);
    dozeMode = 1'b1;
    rdCnt(16'h0003, "R7"); rdCnt(16'h0002, "R7"); rdCnt(16'h0001, "R7");
    rdCnt(16'h0000, "R7"); rdCnt(16'h0003, "R7");
    dozeMode = 1'b0;

    // R8 debug with freeze bit set, write during debug persists
    arm(16'h0004, 16'h001B);
    dbgMode = 1'b1;
    rdCnt(16'h0004, "R8"); rdCnt(16'h0004, "R8");
    wr(3'd2, 1'b1, 16'h0009, 1'b0, "R8");
    rdCnt(16'h0009, "R8"); rdCnt(16'h0009, "R8");
    dbgMode = 1'b0;
    rdCnt(16'h0009, "R8"); rdCnt(16'h0008, "R8");

    // R8 debug with freeze bit clear
    arm(16'h0002, 16'h000B);
    dbgMode = 1'b1;
    rdCnt(16'h0002, "R8"); rdCnt(16'h0001, "R8");
    rdCnt(16'h0000, "R8"); rdCnt(16'h0002, "R8");
    dbgMode = 1'b0;

    // R9 stop via clkEn
    arm(16'h0003, 16'h000B);
    clkEn = 1'b0;
    rdCnt(16'h0003, "R9"); rdCnt(16'h0003, "R9");
    clkEn = 1'b1;
    rdCnt(16'h0003, "R9"); rdCnt(16'h0002, "R9");

    wait (expQ.size() == 0);
    #1;
    done = 1;
    report();
    $finish;
  end
endmodule